// File: doc/BRIEF.md
# Asynchronous List Idle Controller

This block decides when a USB host controller should walk its circular asynchronous transfer list and when it should rest. It keeps a progress flag. Every traversal start event sets the flag, and so does every transaction executed during a walk. A queue head fetched with its list-head marker clears the flag. If such a queue head is fetched while the flag is already clear, the controller has just made a whole lap of the list without doing any work. It then raises a one-cycle empty indication and stops walking.

While it rests, a cycle-count timer runs. When the timer ends, the walk restarts partway through the micro-frame, and that restart counts as a start event. A new micro-frame also ends the rest. When periodic processing is enabled, the micro-frame hands control to the periodic list, and the walk waits for the handoff. When periodic processing is off, the micro-frame start restarts the walk at once.

All inputs are single-cycle event pulses or level enables. The outputs are a walk enable, the empty pulse and the flag.

Top module: `asyncIdleCtl`

## Requirements
- R1: During and straight after reset, `traverseEn`, `emptyPulse` and `reclaimFlag` are all 0.
- R2: With `asyncEn` high, a `perToAsync` pulse is a start event. From the next cycle `traverseEn` is 1 and `reclaimFlag` is 1, whatever the state was.
- R3: With `asyncEn` high, a `uframeStart` pulse takes priority over `perToAsync` and over list events. If `periodicEn` is 0 it is a start event (as in R2). If `periodicEn` is 1 it drops `traverseEn` to 0 and leaves `reclaimFlag` unchanged until a handoff arrives.
- R4: A `txnExecuted` pulse while walking sets `reclaimFlag` to 1. Outside a walk it has no effect on the flag.
- R5: While walking, a `qhFetched` pulse with `qhHeadBit` = 1 and the flag at 1 clears the flag and keeps the walk going. A fetch with `qhHeadBit` = 0 changes nothing.
- R6: While walking, a `qhFetched` pulse with `qhHeadBit` = 1 while the flag is 0, and no `txnExecuted` in the same cycle, gives `emptyPulse` = 1 for exactly one cycle. In that same cycle `traverseEn` falls to 0 and the flag stays 0.
- R7: After an empty detection, `traverseEn` stays 0 for exactly `SLEEP_CYCLES` cycles. The walk then resumes by itself with `reclaimFlag` = 1.
- R8: A `uframeStart` during the rest cancels the timer. With `periodicEn` = 1 the block stays idle, beyond the timer's end, until `perToAsync`. With `periodicEn` = 0 the walk restarts the next cycle.
- R9: While `asyncEn` is 0, `traverseEn` is 0, every event input is ignored, the timer is cleared and `reclaimFlag` holds its value.
- R10: A `txnExecuted` in the same cycle as a list-head fetch wins: the flag ends at 1 and no empty pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodicEn | input | 1 | Periodic list processing enabled |
| asyncEn | input | 1 | Asynchronous list processing enabled |
| uframeStart | input | 1 | Pulse at the start of each micro-frame |
| perToAsync | input | 1 | Pulse when periodic work hands over to the asynchronous list |
| qhFetched | input | 1 | Pulse when a queue head has been fetched during a walk |
| qhHeadBit | input | 1 | List-head marker of the fetched queue head, valid with `qhFetched` |
| txnExecuted | input | 1 | Pulse when a transaction was executed during a walk |
| traverseEn | output | 1 | Asynchronous list walk is allowed |
| emptyPulse | output | 1 | One-cycle pulse: a full lap made no progress |
| reclaimFlag | output | 1 | Progress flag |

## Verification
The hardest case to reach is an empty lap. The bench needs a start event, then a head fetch that clears the flag, then fetches of non-head entries with no transaction, and then a second head fetch. Directed sequences build exactly that lap, including one where a transaction lands in the same cycle as the head fetch. The rest state is then interrupted at chosen points by micro-frame starts with periodic processing on and off, and by dropping the asynchronous enable. A long random phase, biased toward fetches and away from transactions, keeps re-entering the rest state. A behavioural model in the bench is compared with the outputs on every cycle.

// File: rtl/asyncIdlePkg.sv
package asyncIdlePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_NAP  = 2'd2
  } walkState_t;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic loadTimer;
    logic stopTimer;
    logic tick;
  } dpStrobe_t;

endpackage

// File: rtl/asyncIdleDatapath.sv
module asyncIdleDatapath
  import asyncIdlePkg::*;
#(
  parameter int SLEEP_CYCLES = 600
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      flagQ,
  output logic      timerDone
);

  localparam int CW = $clog2(SLEEP_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SLEEP_CYCLES - 1);

  logic [CW-1:0] napCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobe.setFlag) begin
      flagQ <= 1'b1;
    end else if (strobe.clrFlag) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      napCnt <= '0;
    end else if (strobe.stopTimer) begin
      napCnt <= '0;
    end else if (strobe.loadTimer) begin
      napCnt <= RELOAD;
    end else if (strobe.tick && napCnt != '0) begin
      napCnt <= napCnt - 1'b1;
    end
  end

  assign timerDone = (napCnt == '0);

  AST_FLAG_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setFlag, strobe.clrFlag})); // R5

  AST_TIMER_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadTimer, strobe.stopTimer, strobe.tick})); // R7

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    napCnt <= RELOAD); // R7

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopTimer |=> timerDone); // R9

endmodule

// File: rtl/asyncIdleCtrl.sv
module asyncIdleCtrl
  import asyncIdlePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       periodicEn,
  input  logic       asyncEn,
  input  logic       uframeStart,
  input  logic       perToAsync,
  input  logic       qhFetched,
  input  logic       qhHeadBit,
  input  logic       txnExecuted,
  input  logic       flagQ,
  input  logic       timerDone,
  output dpStrobe_t  strobe,
  output walkState_t stateQ,
  output logic       emptyPulse
);

  walkState_t stateD;
  logic       emptyD;
  logic       startEv;

  always_comb begin
    stateD  = stateQ;
    strobe  = '0;
    emptyD  = 1'b0;
    startEv = 1'b0;
    if (!asyncEn) begin
      stateD           = ST_IDLE;
      strobe.stopTimer = 1'b1;
    end else if (uframeStart) begin
      if (periodicEn) begin
        stateD           = ST_IDLE;
        strobe.stopTimer = 1'b1;
      end else begin
        startEv = 1'b1;
      end
    end else if (perToAsync) begin
      startEv = 1'b1;
    end else begin
      unique case (stateQ)
        ST_WALK: begin
          if (txnExecuted) begin
            strobe.setFlag = 1'b1;
          end else if (qhFetched && qhHeadBit) begin
            if (flagQ) begin
              strobe.clrFlag = 1'b1;
            end else begin
              emptyD           = 1'b1;
              stateD           = ST_NAP;
              strobe.loadTimer = 1'b1;
            end
          end
        end
        ST_NAP: begin
          if (timerDone) startEv = 1'b1;
          else           strobe.tick = 1'b1;
        end
        default: ;
      endcase
    end
    if (startEv) begin
      stateD           = ST_WALK;
      strobe.setFlag   = 1'b1;
      strobe.stopTimer = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      emptyPulse <= 1'b0;
    end else begin
      stateQ     <= stateD;
      emptyPulse <= emptyD;
    end
  end

  AST_EMPTY_ENTERS_NAP: assert property (@(posedge clk) disable iff (!rstN)
    emptyPulse |-> (stateQ == ST_NAP && !flagQ)); // R6

  AST_EMPTY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    emptyPulse |=> !emptyPulse); // R6

  AST_WALK_ENTRY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WALK && $past(stateQ) != ST_WALK) |-> flagQ); // R2

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !asyncEn |=> (stateQ == ST_IDLE && !emptyPulse)); // R9

  AST_NAP_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NAP && timerDone && asyncEn && !uframeStart) |=> stateQ == ST_WALK); // R7

  AST_UFRAME_PERIODIC: assert property (@(posedge clk) disable iff (!rstN)
    (asyncEn && uframeStart && periodicEn) |=> (stateQ == ST_IDLE && $stable(flagQ))); // R3

endmodule

// File: rtl/asyncIdleCtl.sv
module asyncIdleCtl
  import asyncIdlePkg::*;
#(
  parameter int SLEEP_CYCLES = 600
) (
  input  logic clk,
  input  logic rstN,
  input  logic periodicEn,
  input  logic asyncEn,
  input  logic uframeStart,
  input  logic perToAsync,
  input  logic qhFetched,
  input  logic qhHeadBit,
  input  logic txnExecuted,
  output logic traverseEn,
  output logic emptyPulse,
  output logic reclaimFlag
);

  dpStrobe_t  strobe;
  walkState_t stateQ;
  logic       flagQ;
  logic       timerDone;

  asyncIdleCtrl ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .periodicEn  (periodicEn),
    .asyncEn     (asyncEn),
    .uframeStart (uframeStart),
    .perToAsync  (perToAsync),
    .qhFetched   (qhFetched),
    .qhHeadBit   (qhHeadBit),
    .txnExecuted (txnExecuted),
    .flagQ       (flagQ),
    .timerDone   (timerDone),
    .strobe      (strobe),
    .stateQ      (stateQ),
    .emptyPulse  (emptyPulse)
  );

  asyncIdleDatapath #(.SLEEP_CYCLES(SLEEP_CYCLES)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flagQ     (flagQ),
    .timerDone (timerDone)
  );

  assign traverseEn  = (stateQ == ST_WALK);
  assign reclaimFlag = flagQ;

endmodule

// File: tb/asyncIdleCtl_test.sv
`timescale 1ns/1ps
module asyncIdleCtl_test;

  localparam int NAP = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periodicEn = 1'b1, asyncEn = 1'b1;
  logic uframeStart = 1'b0, perToAsync = 1'b0;
  logic qhFetched = 1'b0, qhHeadBit = 1'b0, txnExecuted = 1'b0;
  logic traverseEn, emptyPulse, reclaimFlag;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // behavioural reference: 0 idle, 1 walking, 2 resting
  int mSt = 0;
  int mLeft = 0;
  bit mFlag = 0;
  bit mPulse = 0;

  always #2.5 clk = ~clk;

  asyncIdleCtl #(.SLEEP_CYCLES(NAP)) uut (
    .clk(clk), .rstN(rstN), .periodicEn(periodicEn), .asyncEn(asyncEn),
    .uframeStart(uframeStart), .perToAsync(perToAsync), .qhFetched(qhFetched),
    .qhHeadBit(qhHeadBit), .txnExecuted(txnExecuted),
    .traverseEn(traverseEn), .emptyPulse(emptyPulse), .reclaimFlag(reclaimFlag)
  );

  always @(posedge clk) begin : refModel
    int nxt;
    bit go;
    if (!rstN) begin
      mSt = 0; mLeft = 0; mFlag = 0; mPulse = 0;
    end else begin
      nxt = mSt; go = 0; mPulse = 0;
      if (!asyncEn) begin
        nxt = 0; mLeft = 0;
      end else if (uframeStart && periodicEn) begin
        nxt = 0; mLeft = 0;
      end else if (uframeStart || perToAsync) begin
        go = 1;
      end else if (mSt == 1) begin
        if (txnExecuted) mFlag = 1;
        else if (qhFetched && qhHeadBit) begin
          if (mFlag) mFlag = 0;
          else begin mPulse = 1; nxt = 2; mLeft = NAP; end
        end
      end else if (mSt == 2) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) go = 1;
      end
      if (go) begin nxt = 1; mFlag = 1; mLeft = 0; end
      mSt = nxt;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(curReq, "model traverseEn", traverseEn, mSt == 1);
    chk(curReq, "model emptyPulse", emptyPulse, mPulse);
    chk(curReq, "model reclaimFlag", reclaimFlag, mFlag);
  end

  task automatic cyc(input logic fe, input logic hb, input logic tx, input logic pa, input logic uf);
    @(negedge clk);
    qhFetched = fe; qhHeadBit = hb; txnExecuted = tx; perToAsync = pa; uframeStart = uf;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic expectOut(input string req, input logic te, input logic ep, input logic fl);
    chk(req, "traverseEn", traverseEn, te);
    chk(req, "emptyPulse", emptyPulse, ep);
    chk(req, "reclaimFlag", reclaimFlag, fl);
  endtask

  // walk one empty lap: clear at head, pass two entries, hit head again
  task automatic emptyLap();
    cyc(1, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual expired expected completion");
    finishRun();
  end

  initial begin : stim
    int napSeen;
    idle(3);
    curReq = "R1";
    expectOut("R1", 0, 0, 0);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    expectOut("R1", 0, 0, 0);

    curReq = "R2";
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R2", 1, 0, 1);

    curReq = "R5";
    cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R5", 1, 0, 1);
    cyc(1, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R5", 1, 0, 0);

    curReq = "R4";
    cyc(0, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R4", 1, 0, 1);

    curReq = "R10";
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R10", 1, 0, 1);

    curReq = "R6";
    emptyLap();
    expectOut("R6", 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    expectOut("R6", 0, 0, 0);

    curReq = "R7";
    napSeen = 2;
    while (traverseEn == 1'b0 && napSeen < 100) begin
      cyc(0, 0, 0, 0, 0);
      if (traverseEn == 1'b0) napSeen++;
    end
    chk("R7", "rest length", napSeen == NAP, 1'b1);
    expectOut("R7", 1, 0, 1);

    curReq = "R4";
    emptyLap();
    cyc(0, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R4", 0, 0, 0);
    idle(NAP + 2);

    curReq = "R8";
    emptyLap();
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    expectOut("R8", 0, 0, 0);
    idle(NAP + 3);
    expectOut("R8", 0, 0, 0);
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R8", 1, 0, 1);

    periodicEn = 1'b0;
    emptyLap();
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    expectOut("R8", 1, 0, 1);

    curReq = "R3";
    periodicEn = 1'b1;
    cyc(0, 0, 0, 1, 1); cyc(0, 0, 0, 0, 0);
    expectOut("R3", 0, 0, 1);
    periodicEn = 1'b0;
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    expectOut("R3", 1, 0, 1);

    curReq = "R9";
    cyc(1, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    asyncEn = 1'b0;
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1); cyc(1, 1, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    expectOut("R9", 0, 0, 0);
    asyncEn = 1'b1;
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0);
    emptyLap();
    asyncEn = 1'b0;
    idle(NAP + 3);
    expectOut("R9", 0, 0, 0);
    asyncEn = 1'b1;
    idle(NAP + 3);
    expectOut("R9", 0, 0, 0);

    curReq = "R7";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (i % 50 == 0) periodicEn = $urandom_range(0, 1);
      if (i % 700 == 0) asyncEn = ($urandom_range(0, 5) != 0);
      cyc(r < 40, $urandom_range(0, 2) == 0, r >= 40 && r < 44,
          r >= 44 && r < 47, r >= 47 && r < 49);
    end
    asyncEn = 1'b1;
    idle(3);
    finishRun();
  end

endmodule